// File: doc/BRIEF.md
# System Error Status and Mask Unit

This block gathers up to 32 machine-check error sources into one sticky status word. Each source is level-sensitive and is sampled on the clock. When an implemented source is high, its status bit becomes one and holds there until software writes a one to that position. A mask word decides which status bits may reach the processor core. The unit drives a single registered machine-check request, which is high while any unmasked status bit is set.

Software uses a small synchronous register port: an address, a write enable, write data, and read data that returns one cycle after the address is presented. A parameter gives the set of implemented bit positions, in the convention where bit number 0 is the most significant bit of the word. One of these positions belongs to the external IRQ0 pin. It can set its status bit only while the configuration input that routes IRQ0 as a machine-check source is high.

There are two reset inputs. The power-on reset clears everything, status included. The soft/hard reset reloads the mask and clears the output registers, but it leaves the captured status in place. Error information therefore survives a warm restart.

Top module: `mchk_err_unit`

## Requirements
- R1: An implemented status bit becomes one on the clock edge after its source is sampled high, whatever value the matching mask bit holds. The source for bit number n is errIn[31-n].
- R2: mcpReq equals the OR over all positions of status AND mask, taken from the register values one clock earlier. A mask bit of zero keeps its status bit out of the request.
- R3: A write to the status offset clears every status bit where the write data holds a one. Data bits of zero leave status unchanged.
- R4: Only porRstN clears the status register. Asserting sysRstN alone leaves every status bit as it was.
- R5: On either reset, implemented mask bits load one and reserved mask bits load zero. Writes to the mask offset store the write data at implemented positions.
- R6: Reserved positions (IMPL_BITS bit 0) in both registers ignore writes and error inputs, and they always read as zero.
- R7: The status register is at offset 0x40 and the mask register is at offset 0x44. Any other offset reads as zero. rdData shows the register selected by the address sampled at the previous clock edge.
- R8: The IRQ0 status bit (bit number IRQ0_NUM, default 0, which is errIn[31]) sets only while irq0Sel is one. While irq0Sel is zero, its source has no effect.
- R9: If a source is high in the same cycle that software writes a one to clear its bit, the bit stays one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| sysRstN | input | 1 | Soft/hard reset, active low, asynchronous; status kept |
| addr | input | ADDR_W | Register byte offset |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 32 | Write data (one-to-clear for status) |
| rdData | output | 32 | Read data, one cycle after addr |
| errIn | input | 32 | Error sources, errIn[31-n] feeds bit number n |
| irq0Sel | input | 1 | Routes external IRQ0 as a machine-check source |
| mcpReq | output | 1 | Registered machine-check request to the core |

## Verification
The assertions assume that errIn, irq0Sel, wrEn, addr and wrData change only between clock edges. They also assume that a reset deassertion never lands on a clock edge. The bench meets both assumptions by driving every input at the falling edge, including the reset pins, and by sampling rdData and mcpReq at the falling edge as well. Error pulses last exactly one cycle, and the sources are held low during register accesses, except in the deliberate set-versus-clear collision. This keeps each expected status value a function only of the pulses and writes issued so far.

// File: rtl/mchk_pkg.sv
package mchk_pkg;

  localparam int DATA_W = 32;

  // Decoded register-port strobes, produced by the control and consumed by
  // the datapath.
  typedef struct packed {
    logic statWr;   // one-to-clear write to the status word
    logic maskWr;   // store into the mask word
    logic statSel;  // read mux picks status
    logic maskSel;  // read mux picks mask
  } regStrobe_t;

  // Converts a bit number (0 = most significant) to a vector index.
  function automatic int bitNumToIdx(input int bitNum);
    return DATA_W - 1 - bitNum;
  endfunction

endpackage

// File: rtl/mchk_ctrl.sv
module mchk_ctrl
  import mchk_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h44
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);

  logic hitStat;
  logic hitMask;

  assign hitStat = (addr == STAT_OFS);
  assign hitMask = (addr == MASK_OFS);

  always_comb begin
    strb         = '0;
    strb.statSel = hitStat;
    strb.maskSel = hitMask;
    strb.statWr  = wrEn && hitStat;
    strb.maskWr  = wrEn && hitMask;
  end

endmodule

// File: rtl/mchk_dpath.sv
module mchk_dpath
  import mchk_pkg::*;
#(
  parameter logic [DATA_W-1:0] IMPL_BITS = 32'hFFF0_0F0F,
  parameter int                IRQ0_NUM  = 0
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              rstAnyN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] errIn,
  input  logic              irq0Sel,
  output logic [DATA_W-1:0] statQ,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] rdData,
  output logic              mcpReq
);

  localparam int IRQ0_IDX = bitNumToIdx(IRQ0_NUM);

  // One status cell and one mask cell per implemented position.
  for (genvar i = 0; i < DATA_W; i++) begin : gBit
    if (IMPL_BITS[i]) begin : gImpl
      localparam bit IS_IRQ0 = (i == IRQ0_IDX);
      logic setNow;
      logic statBit;
      logic maskBit;

      if (IS_IRQ0) begin : gGate
        assign setNow = errIn[i] & irq0Sel;
      end else begin : gPlain
        assign setNow = errIn[i];
      end

      // Sticky status: only power-on reset clears; set wins over clear.
      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN)                      statBit <= 1'b0;
        else if (setNow)                   statBit <= 1'b1;
        else if (strb.statWr && wrData[i]) statBit <= 1'b0;
      end

      always_ff @(posedge clk or negedge rstAnyN) begin
        if (!rstAnyN)         maskBit <= 1'b1;
        else if (strb.maskWr) maskBit <= wrData[i];
      end

      assign statQ[i] = statBit;
      assign maskQ[i] = maskBit;
    end else begin : gRsvd
      assign statQ[i] = 1'b0;
      assign maskQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstAnyN) begin
    if (!rstAnyN) mcpReq <= 1'b0;
    else          mcpReq <= |(statQ & maskQ);
  end

  always_ff @(posedge clk or negedge rstAnyN) begin
    if (!rstAnyN)          rdData <= '0;
    else if (strb.statSel) rdData <= statQ;
    else if (strb.maskSel) rdData <= maskQ;
    else                   rdData <= '0;
  end

endmodule

// File: rtl/mchk_err_unit.sv
module mchk_err_unit
  import mchk_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 8'h40,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h44,
  parameter logic [31:0]       IMPL_BITS = 32'hFFF0_0F0F,
  parameter int                IRQ0_NUM  = 0
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [31:0]       errIn,
  input  logic              irq0Sel,
  output logic              mcpReq
);

  regStrobe_t        strb;
  logic              rstAnyN;
  logic [DATA_W-1:0] statQ;
  logic [DATA_W-1:0] maskQ;

  assign rstAnyN = porRstN & sysRstN;

  mchk_ctrl #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .MASK_OFS(MASK_OFS)
  ) u_ctrl (
    .wrEn(wrEn),
    .addr(addr),
    .strb(strb)
  );

  mchk_dpath #(
    .IMPL_BITS(IMPL_BITS),
    .IRQ0_NUM (IRQ0_NUM)
  ) u_dpath (
    .clk    (clk),
    .porRstN(porRstN),
    .rstAnyN(rstAnyN),
    .strb   (strb),
    .wrData (wrData),
    .errIn  (errIn),
    .irq0Sel(irq0Sel),
    .statQ  (statQ),
    .maskQ  (maskQ),
    .rdData (rdData),
    .mcpReq (mcpReq)
  );

endmodule

// File: rtl/mchk_err_chk.sv
module mchk_err_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 8'h40,
  parameter logic [31:0]       IMPL_BITS = 32'hFFF0_0F0F,
  parameter int                IRQ0_NUM  = 0
) (
  input logic              clk,
  input logic              porRstN,
  input logic              rstAnyN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [31:0]       wrData,
  input logic [31:0]       errIn,
  input logic              irq0Sel,
  input logic [31:0]       statQ,
  input logic [31:0]       maskQ,
  input logic              mcpReq
);

  localparam int IRQ0_IDX = 31 - IRQ0_NUM;

  logic [31:0] gateVec;
  logic [31:0] liveSrc;

  assign gateVec = irq0Sel ? 32'hFFFF_FFFF : ~(32'h1 << IRQ0_IDX);
  assign liveSrc = errIn & IMPL_BITS & gateVec;

  // R1 and R9: a live source always leaves its bit set, even under a clear.
  a_r1_set_sticks: assert property (@(posedge clk) disable iff (!porRstN)
    (liveSrc != 0) |=> ((statQ & $past(liveSrc)) == $past(liveSrc)));

  // R2: request follows the masked status one cycle later.
  a_r2_mcp_follows: assert property (@(posedge clk) disable iff (!rstAnyN)
    1'b1 |=> (mcpReq == (|($past(statQ) & $past(maskQ)))));

  // R3: an all-zero clear write with no sources leaves status untouched.
  a_r3_zero_write: assert property (@(posedge clk) disable iff (!porRstN)
    (wrEn && addr == STAT_OFS && wrData == 0 && errIn == 0) |=> $stable(statQ));

  // R6: reserved positions stay zero in both registers.
  a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (!porRstN)
    ((statQ & ~IMPL_BITS) == 0) && ((maskQ & ~IMPL_BITS) == 0));

  // R8: with IRQ0 not routed, a clear IRQ0 status bit stays clear.
  a_r8_irq0_gated: assert property (@(posedge clk) disable iff (!porRstN)
    (!irq0Sel && !statQ[IRQ0_IDX]) |=> !statQ[IRQ0_IDX]);

endmodule

bind mchk_err_unit mchk_err_chk #(
  .ADDR_W   (ADDR_W),
  .STAT_OFS (STAT_OFS),
  .IMPL_BITS(IMPL_BITS),
  .IRQ0_NUM (IRQ0_NUM)
) u_chk (
  .clk    (clk),
  .porRstN(porRstN),
  .rstAnyN(rstAnyN),
  .addr   (addr),
  .wrEn   (wrEn),
  .wrData (wrData),
  .errIn  (errIn),
  .irq0Sel(irq0Sel),
  .statQ  (statQ),
  .maskQ  (maskQ),
  .mcpReq (mcpReq)
);

// File: tb/mchk_err_unit_bench.sv
`timescale 1ns/1ps
module mchk_err_unit_bench;

  localparam logic [31:0] IMPL     = 32'hFFF0_0F0F;
  localparam logic [7:0]  OFS_STAT = 8'h40;
  localparam logic [7:0]  OFS_MASK = 8'h44;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        sysRstN = 1'b0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] errIn = '0;
  logic        irq0Sel = 1'b1;
  logic        mcpReq;

  int checks = 0;
  int errors = 0;
  logic [31:0] got;
  logic [31:0] expStat = '0;
  logic [31:0] expMask = IMPL;

  always #5 clk = ~clk;

  mchk_err_unit u_mchk_err_unit (
    .clk    (clk),
    .porRstN(porRstN),
    .sysRstN(sysRstN),
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData),
    .errIn  (errIn),
    .irq0Sel(irq0Sel),
    .mcpReq (mcpReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    tick();
    d = rdData;
  endtask

  task automatic pulseErr(input logic [31:0] v);
    errIn = v;
    tick();
    errIn = '0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    porRstN = 1'b1; sysRstN = 1'b1;
    tick();

    // Reset state: R4 status clear, R5 mask = implemented, R2 no request.
    regRead(OFS_STAT, got); check("R4 status after power-on", got, 32'h0);
    regRead(OFS_MASK, got); check("R5 mask after reset", got, IMPL);
    check("R2 request after reset", {31'b0, mcpReq}, 32'h0);

    // R6: mask writes keep reserved bits zero; R5 write stores implemented.
    regWrite(OFS_MASK, 32'h0);
    regRead(OFS_MASK, got); check("R5 mask write zero", got, 32'h0);
    regWrite(OFS_MASK, 32'hFFFF_FFFF);
    regRead(OFS_MASK, got); check("R6 mask reserved read zero", got, IMPL);

    // R7: unmapped offsets read zero.
    regRead(8'h48, got); check("R7 unmapped 0x48", got, 32'h0);
    regRead(8'h00, got); check("R7 unmapped 0x00", got, 32'h0);
    regRead(8'h41, got); check("R7 unmapped 0x41", got, 32'h0);

    // Sweep every position: set, mask on/off, zero write, one-to-clear.
    for (int i = 0; i < 32; i++) begin
      logic [31:0] oneHot;
      logic [31:0] mk;
      oneHot = 32'h1 << i;
      mk = (i % 2 == 0) ? 32'hFFFF_FFFF : ~oneHot;
      regWrite(OFS_MASK, mk);
      expMask = mk & IMPL;
      pulseErr(oneHot);
      expStat = oneHot & IMPL;
      regRead(OFS_STAT, got); check("R1 R6 status set by source", got, expStat);
      check("R2 request vs mask", {31'b0, mcpReq}, {31'b0, |(expStat & expMask)});
      regWrite(OFS_STAT, 32'h0);
      regRead(OFS_STAT, got); check("R3 zero write no effect", got, expStat);
      regWrite(OFS_STAT, oneHot);
      expStat = '0;
      regRead(OFS_STAT, got); check("R3 one-to-clear", got, expStat);
      tick();
      check("R2 request drops", {31'b0, mcpReq}, 32'h0);
    end
    regWrite(OFS_MASK, 32'hFFFF_FFFF);
    expMask = IMPL;

    // R8: IRQ0 source (errIn[31]) gated by irq0Sel.
    irq0Sel = 1'b0;
    pulseErr(32'h8000_0000);
    regRead(OFS_STAT, got); check("R8 IRQ0 ignored when unrouted", got, 32'h0);
    check("R8 no request when unrouted", {31'b0, mcpReq}, 32'h0);
    irq0Sel = 1'b1;
    pulseErr(32'h8000_0000);
    regRead(OFS_STAT, got); check("R8 IRQ0 sets when routed", got, 32'h8000_0000);
    regWrite(OFS_STAT, 32'hFFFF_FFFF);

    // R9: set wins over a simultaneous clear.
    pulseErr(32'h0000_0101);
    errIn = 32'h0000_0001;
    regWrite(OFS_STAT, 32'h0000_0101);
    errIn = '0;
    regRead(OFS_STAT, got); check("R9 set beats clear", got, 32'h0000_0001);

    // R4/R5: soft reset keeps status, reloads mask.
    regWrite(OFS_MASK, 32'h0);
    pulseErr(32'h0F00_0000);
    sysRstN = 1'b0;
    tick();
    sysRstN = 1'b1;
    tick();
    regRead(OFS_STAT, got); check("R4 status kept on soft reset", got, 32'h0F00_0001);
    regRead(OFS_MASK, got); check("R5 mask reloaded on soft reset", got, IMPL);
    check("R2 request after soft reset", {31'b0, mcpReq}, 32'h1);

    // R4: power-on reset clears status.
    porRstN = 1'b0;
    tick();
    porRstN = 1'b1;
    tick();
    regRead(OFS_STAT, got); check("R4 status cleared by power-on", got, 32'h0);
    tick();
    check("R2 request after power-on", {31'b0, mcpReq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule